// File: doc/BRIEF.md
# Halving-Stride Tree Reduction Engine

This block adds up a power-of-two set of integer values held in a local array. It uses one adder lane per element. Software or a neighbouring block first writes the values through a simple load port while the engine is idle. A start pulse then launches the reduction. The sum wraps modulo 2^W.

Each iteration begins with a one-cycle barrier. In that cycle no lane writes. It is followed by one execute cycle, in which every enabled lane adds its partner element into its own element in parallel.

The default mode starts the stride at half the block size and halves it each iteration. In this mode the active lanes stay packed at the low indices, and whole lane groups go idle early. The other mode starts at stride one and doubles it. In that mode only lanes whose index is a multiple of twice the stride take part. Both modes must leave the same total in element 0.

After each execute cycle the block reports two figures for that iteration:
- the number of active lanes;
- the number of lane groups that hold at least one active lane.

These figures let the two modes be compared by their utilisation.

Top module: `tree_sum_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `step_valid` are 0 and `sum_out` is 0.
- R2: While idle, a cycle with `load_en` high writes `load_data` into element `load_addr`. Every element written this way contributes to the next sum.
- R3: With `mode` = 0 (halving), the stride starts at N/2 and halves each iteration down to 1. Lane t is active when t < stride and adds element t+stride into element t. When `done` pulses, `sum_out` equals the sum of all N elements modulo 2^W.
- R4: With `mode` = 1 (doubling), the stride starts at 1 and doubles each iteration up to N/2. Lane t is active when t mod (2·stride) = 0. It gives the same sum as R3 for the same data.
- R5: `done` is high for exactly one cycle. It rises 2·log2(N)+1 clock edges after the edge that accepts `start`.
- R6: Each run gives exactly log2(N) `step_valid` pulses. `step_lanes` starts at N/2 and halves with every pulse, in both modes.
- R7: In halving mode, `step_groups` equals ceil(stride/G) for the iteration just executed.
- R8: In doubling mode, `step_groups` equals N/G while 2·stride ≤ G. Otherwise it equals N/(2·stride). In both cases this is min(`step_lanes`, N/G).
- R9: A `start` pulse while `busy` is 1 is ignored, together with the `mode` value beside it. The run in progress keeps its timing, its counts and its sum, and no extra run follows.
- R10: A `load_en` cycle while `busy` is 1 does not change any element, so the run in progress yields the sum of the data loaded before it started.
- R11: A `start` in the cycle where `done` is high is accepted. The new run reduces the array exactly as the previous run left it.
- R12: Every execute cycle is preceded by a barrier cycle, so `step_valid` pulses are never adjacent. Within one run they come exactly two cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled while idle |
| mode | input | 1 | 0 = halving stride, 1 = doubling stride; sampled with an accepted start |
| load_en | input | 1 | Element write strobe, honoured only while idle |
| load_addr | input | log2(N) | Element index to write |
| load_data | input | W | Value to write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse with the final sum |
| sum_out | output | W | Total of all elements, valid when `done` pulses |
| step_valid | output | 1 | Pulse after each execute cycle |
| step_lanes | output | log2(N)+1 | Active lanes in the iteration just executed |
| step_groups | output | log2(N/G)+1 | Lane groups with any active lane in that iteration |

## Verification
The completion pulse of one run and the acceptance of the next start can share a cycle. The bench waits for `done` and raises `start` in that same cycle with the other mode. It then expects a fresh, correctly timed sequence of step reports and a second sum, both computed from the array the first run left behind. A start or a load arriving mid-run also shares cycles with lane writes. The scoreboard judges those cases by requiring that the run's reports and sum are unchanged and that no report arrives that was not expected.

// File: rtl/tsum_pkg.sv
package tsum_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_DRAIN = 2'd3
  } tsum_state_e;

  typedef enum logic {
    MODE_HALVE  = 1'b0,
    MODE_DOUBLE = 1'b1
  } tsum_mode_e;

endpackage

// File: rtl/tsum_ctrl.sv
module tsum_ctrl
  import tsum_pkg::*;
#(
  parameter int unsigned N = 64,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  tsum_mode_e      mode_in,
  output tsum_state_e     state_q,
  output tsum_mode_e      mode_q,
  output logic [AW-1:0]   stride_q,
  output logic            last_iter
);

  localparam logic [AW-1:0] STRIDE_ONE  = AW'(1);
  localparam logic [AW-1:0] STRIDE_HALF = AW'(N / 2);

  // final iteration: halving ends at stride 1, doubling ends at stride N/2
  assign last_iter = (mode_q == MODE_HALVE) ? (stride_q == STRIDE_ONE)
                                            : (stride_q == STRIDE_HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_HALVE;
      stride_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_SYNC;
            mode_q   <= mode_in;
            stride_q <= (mode_in == MODE_DOUBLE) ? STRIDE_ONE : STRIDE_HALF;
          end
        end
        ST_SYNC: state_q <= ST_EXEC;
        ST_EXEC: begin
          if (last_iter) begin
            state_q <= ST_DRAIN;
          end else begin
            state_q  <= ST_SYNC;
            stride_q <= (mode_q == MODE_HALVE) ? (stride_q >> 1) : (stride_q << 1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tsum_lanes.sv
module tsum_lanes
  import tsum_pkg::*;
#(
  parameter int unsigned N = 64,
  parameter int unsigned W = 16,
  parameter int unsigned G = 8,
  localparam int unsigned AW = $clog2(N),
  localparam int unsigned NG = N / G,
  localparam int unsigned GW = $clog2(NG) + 1
) (
  input  tsum_mode_e            mode,
  input  logic [AW-1:0]         stride,
  input  logic [N-1:0][W-1:0]   elems,
  output logic [N-1:0]          en,
  output logic [N-1:0][W-1:0]   sums,
  output logic [AW:0]           lane_cnt,
  output logic [GW-1:0]         grp_cnt
);

  logic [AW:0] s_ext;
  logic [AW:0] pair_mask;
  logic [NG-1:0] grp_act;

  assign s_ext     = {1'b0, stride};
  assign pair_mask = {stride, 1'b0} - {{AW{1'b0}}, 1'b1};

  for (genvar e = 0; e < N; e++) begin : g_lane
    localparam logic [AW:0] EI = (AW+1)'(e);
    logic [AW:0] partner;
    logic        hit_halve;
    logic        hit_double;

    assign partner    = EI + s_ext;
    assign hit_halve  = EI < s_ext;
    assign hit_double = ((EI & pair_mask) == '0) && (partner < (AW+1)'(N));
    assign en[e]      = (mode == MODE_HALVE) ? hit_halve : hit_double;
    assign sums[e]    = elems[e] + elems[partner[AW-1:0]];
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_act[g] = |en[g*G +: G];
  end

  always_comb begin
    lane_cnt = '0;
    for (int i = 0; i < N; i++) lane_cnt = lane_cnt + (AW+1)'(en[i]);
  end

  always_comb begin
    grp_cnt = '0;
    for (int i = 0; i < NG; i++) grp_cnt = grp_cnt + GW'(grp_act[i]);
  end

endmodule

// File: rtl/tsum_bank.sv
module tsum_bank #(
  parameter int unsigned N = 64,
  parameter int unsigned W = 16,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  load_we,
  input  logic [AW-1:0]         load_addr,
  input  logic [W-1:0]          load_data,
  input  logic [N-1:0]          lane_we,
  input  logic [N-1:0][W-1:0]   lane_wd,
  output logic [N-1:0][W-1:0]   cells
);

  // lane writes and load writes never overlap: the top gates them by state
  always_ff @(posedge clk) begin
    for (int e = 0; e < N; e++) begin
      if (lane_we[e]) begin
        cells[e] <= lane_wd[e];
      end else if (load_we && (load_addr == AW'(e))) begin
        cells[e] <= load_data;
      end
    end
  end

endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine
  import tsum_pkg::*;
#(
  parameter int unsigned N = 64,
  parameter int unsigned W = 16,
  parameter int unsigned G = 8,
  localparam int unsigned AW = $clog2(N),
  localparam int unsigned GW = $clog2(N / G) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            mode,
  input  logic            load_en,
  input  logic [AW-1:0]   load_addr,
  input  logic [W-1:0]    load_data,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    sum_out,
  output logic            step_valid,
  output logic [AW:0]     step_lanes,
  output logic [GW-1:0]   step_groups
);

  tsum_state_e          state_q;
  tsum_mode_e           run_mode;
  logic [AW-1:0]        stride_q;
  logic                 last_iter;
  logic                 run_dbl;
  logic                 exec;
  logic [N-1:0]         lane_en;
  logic [N-1:0]         lane_we;
  logic [N-1:0][W-1:0]  lane_sum;
  logic [N-1:0][W-1:0]  cells;
  logic [AW:0]          lane_cnt;
  logic [GW-1:0]        grp_cnt;

  tsum_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode_in   (tsum_mode_e'(mode)),
    .state_q   (state_q),
    .mode_q    (run_mode),
    .stride_q  (stride_q),
    .last_iter (last_iter)
  );

  tsum_lanes #(.N(N), .W(W), .G(G)) u_lanes (
    .mode     (run_mode),
    .stride   (stride_q),
    .elems    (cells),
    .en       (lane_en),
    .sums     (lane_sum),
    .lane_cnt (lane_cnt),
    .grp_cnt  (grp_cnt)
  );

  assign exec    = (state_q == ST_EXEC);
  assign lane_we = exec ? lane_en : '0;
  assign busy    = (state_q != ST_IDLE);
  assign run_dbl = (run_mode == MODE_DOUBLE);

  tsum_bank #(.N(N), .W(W)) u_bank (
    .clk       (clk),
    .load_we   (load_en && (state_q == ST_IDLE)),
    .load_addr (load_addr),
    .load_data (load_data),
    .lane_we   (lane_we),
    .lane_wd   (lane_sum),
    .cells     (cells)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      sum_out     <= '0;
      step_valid  <= 1'b0;
      step_lanes  <= '0;
      step_groups <= '0;
    end else begin
      step_valid <= exec;
      if (exec) begin
        step_lanes  <= lane_cnt;
        step_groups <= grp_cnt;
      end
      done <= (state_q == ST_DRAIN);
      if (state_q == ST_DRAIN) sum_out <= cells[0];
    end
  end

endmodule

// File: rtl/tree_sum_engine_chk.sv
module tree_sum_engine_chk #(
  parameter int N = 64,
  parameter int G = 8,
  localparam int AW = $clog2(N),
  localparam int NG = N / G,
  localparam int GW = $clog2(NG) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            step_valid,
  input logic [AW:0]     step_lanes,
  input logic [GW-1:0]   step_groups,
  input logic [AW-1:0]   stride,
  input logic            run_dbl
);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R12
  barrier_gap_chk: assert property (@(posedge clk) disable iff (rst)
    step_valid |=> !step_valid);

  // R6
  lanes_halve_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && $past(step_valid, 2)) |-> ({step_lanes, 1'b0} == {1'b0, $past(step_lanes, 2)}));

  // R6
  stride_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($onehot0(stride) && (stride != '0)));

  // R7
  halve_groups_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !run_dbl) |->
      ((int'(step_groups) * G >= int'(step_lanes)) && ((int'(step_groups) - 1) * G < int'(step_lanes))));

  // R8
  double_groups_chk: assert property (@(posedge clk) disable iff (rst)
    (step_valid && run_dbl) |->
      (int'(step_groups) == ((int'(step_lanes) >= NG) ? NG : int'(step_lanes))));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

endmodule

bind tree_sum_engine tree_sum_engine_chk #(.N(N), .G(G)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .step_valid  (step_valid),
  .step_lanes  (step_lanes),
  .step_groups (step_groups),
  .stride      (stride_q),
  .run_dbl     (run_dbl)
);

// File: tb/tree_sum_engine_test.sv
`timescale 1ns/1ps
module tree_sum_engine_test;

  localparam int N  = 64;
  localparam int W  = 16;
  localparam int G  = 8;
  localparam int AW = $clog2(N);
  localparam int L  = $clog2(N);
  localparam int GW = $clog2(N / G) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [W-1:0]  load_data = '0;
  logic busy, done, step_valid;
  logic [W-1:0]  sum_out;
  logic [AW:0]   step_lanes;
  logic [GW-1:0] step_groups;

  tree_sum_engine #(.N(N), .W(W), .G(G)) uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .busy(busy), .done(done), .sum_out(sum_out),
    .step_valid(step_valid), .step_lanes(step_lanes), .step_groups(step_groups)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    bit    fin;
    bit    dbl;
    int    lanes;
    int    groups;
    int    sum;
    int    at;
    string req;
  } item_t;

  item_t sb[$];
  logic [W-1:0] model[N];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pop expected items as outputs appear
  always @(negedge clk) begin
    item_t it;
    if (!rst && (step_valid || done)) begin
      if (sb.size() == 0) begin
        check(0, "R9", "unexpected output at cycle", cyc, -1);
      end else begin
        it = sb.pop_front();
        if (!it.fin) begin
          check(step_valid, "R6", "step report present", int'(step_valid), 1);
          check(int'(step_lanes) == it.lanes, "R6", "active lanes", int'(step_lanes), it.lanes);
          check(int'(step_groups) == it.groups, it.dbl ? "R8" : "R7", "active groups",
                int'(step_groups), it.groups);
          check(cyc == it.at, "R12", "step cycle", cyc, it.at);
        end else begin
          check(done, "R5", "done present", int'(done), 1);
          check(int'(sum_out) == it.sum, it.req, "sum", int'(sum_out), it.sum);
          check(cyc == it.at, "R5", "done cycle", cyc, it.at);
        end
      end
    end
  end

  // R2: idle load, mirrored into the bench model
  task automatic load_word(int addr, int data);
    load_en   = 1'b1;
    load_addr = AW'(addr);
    load_data = W'(data);
    model[addr] = W'(data);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic load_ramp(int mul, int add);
    for (int i = 0; i < N; i++) load_word(i, i * mul + add);
  endtask

  // driver: push expected reports, then pulse start
  task automatic launch(bit m, string req);
    int k = cyc;
    int i = 1;
    item_t it;
    if (!m) begin
      for (int s = N / 2; s >= 1; s = s / 2) begin
        for (int t = 0; t < s; t++) model[t] = model[t] + model[t + s];
        it = '{fin: 0, dbl: 0, lanes: s, groups: (s + G - 1) / G, sum: 0, at: k + 1 + 2 * i, req: req};
        sb.push_back(it);
        i++;
      end
    end else begin
      for (int s = 1; s < N; s = s * 2) begin
        for (int t = 0; t < N; t = t + 2 * s) model[t] = model[t] + model[t + s];
        it = '{fin: 0, dbl: 1, lanes: N / (2 * s), groups: (2 * s <= G) ? N / G : N / (2 * s),
               sum: 0, at: k + 1 + 2 * i, req: req};
        sb.push_back(it);
        i++;
      end
    end
    it = '{fin: 1, dbl: m, lanes: 0, groups: 0, sum: int'(model[0]), at: k + 2 + 2 * L, req: req};
    sb.push_back(it);
    start = 1'b1;
    mode  = m;
    @(negedge clk);
    start = 1'b0;
    mode  = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values
    check(!busy, "R1", "busy in reset", int'(busy), 0);
    check(!done, "R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!step_valid, "R1", "step_valid after reset", int'(step_valid), 0);
    check(sum_out == '0, "R1", "sum after reset", int'(sum_out), 0);

    // R2 / R3: ramp data, halving mode
    load_ramp(1, 1);
    launch(1'b0, "R2");
    wait_idle();

    // R4: doubling mode, different data
    load_ramp(3, 7);
    launch(1'b1, "R4");
    wait_idle();

    // R3: wraparound, all elements at the maximum value
    load_ramp(0, 16'hFFFF);
    launch(1'b0, "R3");
    wait_idle();

    // R9: start plus mode change mid-run must be ignored
    load_ramp(5, 2);
    launch(1'b0, "R9");
    repeat (3) @(negedge clk);
    start = 1'b1;
    mode  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mode  = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    check(!busy, "R9", "engine idle after ignored start", int'(busy), 0);

    // R10: load during a run must not touch the array
    load_ramp(7, 11);
    launch(1'b1, "R10");
    repeat (4) @(negedge clk);
    load_en   = 1'b1;
    load_addr = '0;
    load_data = W'(16'h1234);
    @(negedge clk);
    load_en = 1'b0;
    wait_idle();

    // R11: start accepted in the cycle done is high, mode switched
    load_ramp(2, 9);
    launch(1'b0, "R11");
    do @(negedge clk); while (!done);
    launch(1'b1, "R11");
    wait_idle();

    check(sb.size() == 0, "R9", "leftover expected items", sb.size(), 0);
    summary();
  end

endmodule